// File: doc/BRIEF.md
# Ternary Difference Spike Encoder

This block follows one neuron's target value with an announced "actual" value, both signed 16-bit fixed point with eight fraction bits by default. Each accepted step compares the two and emits a ternary spike: +1 when the target lies above the actual value by more than the current threshold, -1 when it lies below by more than the threshold, and 0 otherwise. A nonzero spike moves the actual value one threshold step toward the target. Only the increments travel downstream, so a settled value produces nothing but zero spikes. The same encoder serves activity values and error values.

The threshold arrives with each step as a signed shift exponent k. The threshold is 2^k in value units, which is 2^(k+FRAC) in LSBs, so each update is a shift and an add with no multiplier. An optional rectifying gate cancels any spike that would leave the actual value at or below zero. A load port writes the actual value directly without producing a spike; it is used for a feedforward initialisation pass. Steps enter on a valid/ready handshake and results leave through a one-entry registered output with valid/ready. The upstream side sees back-pressure whenever the output holds an unconsumed beat or a load is in progress.

Top module: `tdse_encoder`

## Requirements
- R1: After reset, actual_value is 0, out_valid is 0 and out_spike is 2'b00.
- R2: On an accepted step where target minus actual is strictly greater than the threshold, the output beat carries code 2'b01 (+1) and actual_value rises by exactly the threshold.
- R3: On an accepted step where actual minus target is strictly greater than the threshold, the output beat carries code 2'b11 (-1) and actual_value falls by exactly the threshold.
- R4: When the absolute gap is less than or equal to the threshold, including exact equality, the beat carries 2'b00 and actual_value is unchanged.
- R5: The threshold in LSBs is 2^(k+FRAC), where k is in_shift read as signed. The exponent k+FRAC is clamped to the range 0 to W-2.
- R6: With cfg_rectify high, a spike whose result actual ± threshold would not be strictly positive is cancelled (code 2'b00, actual unchanged). With cfg_rectify low, no spike is cancelled.
- R7: A cycle with load_en high sets actual_value to load_value on the next edge. It produces no output beat, and in_ready is low while load_en is high.
- R8: in_ready is high only when the output register is empty or is being drained (out_ready high). While out_valid is high and out_ready is low, out_spike holds.
- R9: Every accepted step produces exactly one output beat, in acceptance order, and out_spike never shows 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rectify | input | 1 | Enables the rectifying gate |
| load_en | input | 1 | Writes load_value into the actual value |
| load_value | input | W | Value written by a load |
| in_valid | input | 1 | Step request with target and exponent |
| in_ready | output | 1 | Encoder can accept a step |
| in_target | input | W | Target value, two's complement |
| in_shift | input | SW | Signed threshold exponent k |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_spike | output | 2 | Spike code: 00 zero, 01 plus, 11 minus |
| actual_value | output | W | Current actual value |

## Verification
The assertions assume that cfg_rectify and load_value are steady on any cycle where they matter. They also assume that a load is never issued while the consumer still needs the actual value that matches a pending beat. The stimulus changes cfg_rectify only between drained phases, and it loads only after the output register and the expected-result queue are empty. Exponents are driven both inside and outside the clamp window, and out_ready alternates between always-on, a pseudo-random pattern and a forced stall, so back-pressure is exercised without breaking those assumptions.

// File: rtl/tdse_pkg.sv
package tdse_pkg;
  typedef enum logic [1:0] {
    SPK_ZERO = 2'b00,
    SPK_POS  = 2'b01,
    SPK_NEG  = 2'b11
  } spike_t;
endpackage

// File: rtl/tdse_thresh.sv
// Converts a signed exponent into a one-hot threshold magnitude in LSBs.
module tdse_thresh #(
  parameter int W    = 16,
  parameter int SW   = 5,
  parameter int FRAC = 8
) (
  input  logic signed [SW-1:0] shift_exp,
  output logic        [W:0]    thr_mag
);
  localparam int EMAX = W - 2;
  localparam int EW   = $clog2(W);

  logic [EW-1:0] e_clamped;

  always_comb begin
    int e;
    e = int'(shift_exp) + FRAC;
    if (e < 0)         e_clamped = '0;
    else if (e > EMAX) e_clamped = EW'(EMAX);
    else               e_clamped = EW'(e);
    thr_mag = (W+1)'(1) << e_clamped;
  end
endmodule

// File: rtl/tdse_decide.sv
// Compare, rectify and compute the next actual value for one step.
module tdse_decide
  import tdse_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] target,
  input  logic signed [W-1:0] actual,
  input  logic        [W:0]   thr_mag,
  input  logic                rectify,
  output spike_t              spike,
  output logic signed [W-1:0] next_actual
);
  localparam int GW = W + 2;
  localparam logic signed [GW-1:0] VMAX = GW'((2 ** (W-1)) - 1);
  localparam logic signed [GW-1:0] VMIN = -GW'(2 ** (W-1));

  logic signed [GW-1:0] tgt_x, act_x, thr_x, gap, neg_gap, sum_up, sum_dn, moved;
  logic go_up, go_dn;

  assign tgt_x   = GW'(target);
  assign act_x   = GW'(actual);
  assign thr_x   = $signed({1'b0, thr_mag});
  assign gap     = tgt_x - act_x;
  assign neg_gap = act_x - tgt_x;
  assign sum_up  = act_x + thr_x;
  assign sum_dn  = act_x - thr_x;

  always_comb begin
    go_up = (gap > thr_x)     && !(rectify && sum_up <= 0);
    go_dn = (neg_gap > thr_x) && !(rectify && sum_dn <= 0);
    if (go_up)      begin spike = SPK_POS;  moved = sum_up; end
    else if (go_dn) begin spike = SPK_NEG;  moved = sum_dn; end
    else            begin spike = SPK_ZERO; moved = act_x;  end
    if (moved > VMAX)      next_actual = VMAX[W-1:0];
    else if (moved < VMIN) next_actual = VMIN[W-1:0];
    else                   next_actual = moved[W-1:0];
  end
endmodule

// File: rtl/tdse_encoder.sv
module tdse_encoder
  import tdse_pkg::*;
#(
  parameter int W    = 16,
  parameter int SW   = 5,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_rectify,
  input  logic                load_en,
  input  logic [W-1:0]        load_value,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [W-1:0]        in_target,
  input  logic [SW-1:0]       in_shift,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [1:0]          out_spike,
  output logic [W-1:0]        actual_value
);
  logic        [W:0]   thr_mag;
  spike_t              spike_c;
  logic signed [W-1:0] next_c;
  logic signed [W-1:0] actual_q;
  spike_t              spike_q;
  logic                accept;

  tdse_thresh #(.W(W), .SW(SW), .FRAC(FRAC)) u_thr (
    .shift_exp (signed'(in_shift)),
    .thr_mag   (thr_mag)
  );

  tdse_decide #(.W(W)) u_dec (
    .target      (signed'(in_target)),
    .actual      (actual_q),
    .thr_mag     (thr_mag),
    .rectify     (cfg_rectify),
    .spike       (spike_c),
    .next_actual (next_c)
  );

  assign in_ready = (!out_valid || out_ready) && !load_en;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actual_q  <= '0;
      spike_q   <= SPK_ZERO;
      out_valid <= 1'b0;
    end else begin
      if (load_en) begin
        actual_q <= signed'(load_value);
      end else if (accept) begin
        actual_q <= next_c;
      end
      if (accept) begin
        spike_q   <= spike_c;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_spike    = spike_q;
  assign actual_value = actual_q;

  // R2 R3 R4: direction of the actual-value move matches the spike code
  a_r2_r3_r4_move_matches: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((out_spike != 2'b01 || actual_q >  $past(actual_q)) &&
                (out_spike != 2'b11 || actual_q <  $past(actual_q)) &&
                (out_spike != 2'b00 || actual_q == $past(actual_q))));

  a_r6_stays_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_rectify && actual_q > 0) |=> actual_q > 0);

  a_r7_load_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !(out_valid && !out_ready)) |=> !out_valid);

  a_r8_hold_spike: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_spike)));

  a_r9_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_spike != 2'b10);
endmodule

// File: tb/sim_tdse_encoder.sv
module sim_tdse_encoder;
  localparam int W = 16, SW = 5, FRAC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rectify = 1'b0;
  logic load_en = 1'b0;
  logic [W-1:0] load_value = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_target = '0;
  logic [SW-1:0] in_shift = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [1:0] out_spike;
  logic [W-1:0] actual_value;

  always #10 clk = ~clk;  // 50 MHz

  tdse_encoder #(.W(W), .SW(SW), .FRAC(FRAC)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rectify(cfg_rectify),
    .load_en(load_en), .load_value(load_value),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_target(in_target), .in_shift(in_shift),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_spike(out_spike), .actual_value(actual_value)
  );

  int checks = 0;
  int errors = 0;
  int model_act = 0;
  int ready_mode = 0;  // 0 always, 1 pseudo-random, 2 stalled
  logic [7:0] lfsr = 8'hA5;
  int cycles = 0;
  bit done = 0;

  int    q_spk[$];
  int    q_act[$];
  string q_tag[$];

  task automatic report_done();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int thr_of(input int k);
    int e;
    e = k + FRAC;
    if (e < 0) e = 0;
    if (e > W - 2) e = W - 2;
    return 1 << e;
  endfunction

  function automatic int s16(input logic [W-1:0] v);
    return int'(signed'(v));
  endfunction

  always @(posedge clk) begin
    cycles++;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      report_done();
    end
  end

  always @(posedge clk) begin
    #2;
    out_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
  end

  // Monitor: pop and compare each consumed beat
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q_spk.size() == 0) begin
        check(0, "R9 unexpected beat", int'(out_spike), -1);
      end else begin
        int es, ea;
        string tg;
        es = q_spk.pop_front();
        ea = q_act.pop_front();
        tg = q_tag.pop_front();
        check(out_spike == 2'(es), {tg, " spike"}, int'(out_spike), es);
        check(s16(actual_value) == ea, {tg, " actual"}, s16(actual_value), ea);
      end
    end
  end

  // Driver: issue one step and push its expected result
  task automatic step(input int tgt, input int k, input string tag);
    int thr, gap, s, code;
    @(posedge clk); #2;
    in_valid  = 1'b1;
    in_target = W'(tgt);
    in_shift  = SW'(k);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    thr = thr_of(k);
    gap = tgt - model_act;
    s = 0;
    if (gap > thr) s = 1;
    else if (-gap > thr) s = -1;
    if (cfg_rectify && s != 0 && model_act + s * thr <= 0) s = 0;
    model_act = model_act + s * thr;
    code = (s == 1) ? 1 : (s == -1) ? 3 : 0;
    q_spk.push_back(code);
    q_act.push_back(model_act);
    q_tag.push_back(tag);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (q_spk.size() != 0 || out_valid) @(negedge clk);
  endtask

  task automatic do_load(input int v);
    drain();
    @(posedge clk); #2;
    load_en = 1'b1;
    load_value = W'(v);
    @(negedge clk);
    check(in_ready == 1'b0, "R7 in_ready during load", int'(in_ready), 0);
    @(posedge clk); #2;
    load_en = 1'b0;
    model_act = v;
    @(negedge clk);
    check(s16(actual_value) == v, "R7 loaded value", s16(actual_value), v);
    check(out_valid == 1'b0, "R7 no beat from load", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(s16(actual_value) == 0, "R1 actual after reset", s16(actual_value), 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(out_spike == 2'b00, "R1 spike after reset", int'(out_spike), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;

    // Upward tracking, k=0 gives 256 LSB; then finer step k=-1 (128)
    do_load(0);
    for (int i = 0; i < 4; i++) step(1000, 0, "R2 climb");
    step(1000, -1, "R2 finer step");
    // Equal gap boundary: 256 - 0 == 256 -> no spike; 257 -> +1
    do_load(0);
    step(256, 0, "R4 equal gap");
    step(257, 0, "R2 just over");
    step(257, 0, "R4 settled");
    // Downward tracking, rectifier off
    do_load(1000);
    for (int i = 0; i < 6; i++) step(-1000, 0, "R3 descend");
    // Rectifier on
    ready_mode = 1;
    cfg_rectify = 1'b1;
    do_load(200);
    step(-1000, 0, "R6 cancel down");
    do_load(3);
    for (int i = 0; i < 4; i++) step(0, -8, "R6 floor at one");
    do_load(-1000);
    step(0, 0, "R6 cancel up");
    drain();
    cfg_rectify = 1'b0;
    do_load(-1000);
    step(0, 0, "R6 off allows up");
    step(-1000, 0, "R6 off allows down");
    // Clamp: k=-15 -> 1 LSB, k=15 -> 16384 LSB
    do_load(0);
    step(5, -15, "R5 low clamp");
    step(5, -15, "R5 low clamp again");
    do_load(-20000);
    step(20000, 15, "R5 high clamp");
    step(20000, 15, "R5 high clamp again");
    step(20000, 15, "R5 high clamp third");
    // Stream under random back-pressure, mixed exponents
    do_load(0);
    for (int i = 0; i < 24; i++)
      step((i % 2 == 0) ? 3000 - i * 97 : -2500 + i * 53, (i % 5) - 3, "R9 stream order");
    drain();
    // Stall: output holds while out_ready low
    ready_mode = 2;
    do_load(0);
    step(900, 0, "R8 held beat");
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
    check(in_ready == 1'b0, "R8 back-pressure", int'(in_ready), 0);
    check(out_spike == 2'b01, "R8 spike held", int'(out_spike), 1);
    ready_mode = 0;
    drain();
    check(q_spk.size() == 0, "R9 queue empty", q_spk.size(), 0);
    report_done();
  end
endmodule